// File: doc/BRIEF.md
# Fourteen-Operation 8-bit ALU

This block is a clocked arithmetic and logic unit for 8-bit operands. A 4-bit function code selects one of fourteen operations: arithmetic, bitwise logic, comparison or a single-bit shift of operand A. The result is 16 bits wide, so a full product fits.

The result is registered and comes with a valid strobe. Both update on the clock edge that samples the enable input high. The enable is meant to come from a clock-gating controller: when it is low the unit does no work, the strobe drops and the last result stays on the output.

Top module: `alu14_top`

## Requirements
- R1: While rst_ni is low, result_o is 0 and valid_o is 0. Reset acts at once, without waiting for a clock edge, and overrides an enable in the same cycle.
- R2: An edge that samples en_i high sets valid_o to 1 and loads result_o with the operation chosen by func_i. Enables on consecutive cycles give a new result on each cycle, and valid_o stays high.
- R3: An edge that samples en_i low clears valid_o. result_o keeps its previous value even when the operands or the function code change.
- R4: Code 0 (add) gives the 9-bit sum op_a_i + op_b_i, zero-extended to 16 bits.
- R5: Code 1 (subtract) gives op_a_i - op_b_i modulo 2^16. A negative difference therefore appears as a 16-bit two's-complement value.
- R6: Code 2 (multiply) gives the full 16-bit product of op_a_i and op_b_i.
- R7: Code 3 (divide) gives the integer quotient op_a_i / op_b_i, zero-extended. A zero divisor gives 16'hFFFF.
- R8: The bitwise codes are 4 = AND, 5 = OR, 6 = NAND, 7 = NOR, 8 = XOR and 9 = XNOR. Each is applied to the 8-bit operands, and the upper byte is zero.
- R9: Code 10 tests whether A equals B, and code 11 tests whether A is greater than B (unsigned). Bit 0 holds 1 when the test is true and 0 when it is false; all other bits are 0.
- R10: Code 12 gives op_a_i shifted right by one with a zero fill. Code 13 gives op_a_i shifted left by one as a 9-bit value ({op_a_i, 1'b0}), zero-extended.
- R11: Codes 14 and 15 give a zero result, and valid_o is still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Operation enable, from the clock-gating controller |
| op_a_i | input | 8 | Operand A |
| op_b_i | input | 8 | Operand B |
| func_i | input | 4 | Function code |
| result_o | output | 16 | Registered result |
| valid_o | output | 1 | High for each cycle that follows a sampled enable |

## Verification
Two pairs of functions can meet in one cycle. Reset can arrive while an enabled operation is being captured. The bench raises en_i with a live multiply and then pulls rst_ni low in the middle of that cycle; both outputs must then read zero, with no product. A hold can also coincide with changing inputs. After a result is captured, en_i is dropped while the operands and the function code change. The bench requires the earlier result to stay unchanged and valid_o to fall.

// File: rtl/alu14_pkg.sv
package alu14_pkg;
  localparam int unsigned FUNC_W = 4;

  typedef enum logic [FUNC_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MUL  = 4'd2,
    OP_DIV  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_NAND = 4'd6,
    OP_NOR  = 4'd7,
    OP_XOR  = 4'd8,
    OP_XNOR = 4'd9,
    OP_EQ   = 4'd10,
    OP_GT   = 4'd11,
    OP_SHR  = 4'd12,
    OP_SHL  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;
endpackage

// File: rtl/alu14_arith.sv
module alu14_arith
  import alu14_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned RES_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_op_e           op_i,
  output logic [RES_W-1:0]  res_o
);
  logic [RES_W-1:0] a_x, b_x;
  assign a_x = {{DATA_W{1'b0}}, a_i};
  assign b_x = {{DATA_W{1'b0}}, b_i};

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = a_x + b_x;
      OP_SUB:  res_o = a_x - b_x;
      OP_MUL:  res_o = a_x * b_x;
      OP_DIV:  res_o = (b_i == '0) ? {RES_W{1'b1}} : (a_x / b_x);
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu14_logic.sv
module alu14_logic
  import alu14_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned RES_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_op_e           op_i,
  output logic [RES_W-1:0]  res_o
);
  localparam int unsigned PAD_W = RES_W - DATA_W;

  logic [DATA_W-1:0] bw;
  logic              cmp;
  logic              is_cmp;
  logic              is_shl;

  always_comb begin
    bw     = '0;
    cmp    = 1'b0;
    is_cmp = 1'b0;
    is_shl = 1'b0;
    unique case (op_i)
      OP_AND:  bw = a_i & b_i;
      OP_OR:   bw = a_i | b_i;
      OP_NAND: bw = ~(a_i & b_i);
      OP_NOR:  bw = ~(a_i | b_i);
      OP_XOR:  bw = a_i ^ b_i;
      OP_XNOR: bw = ~(a_i ^ b_i);
      OP_EQ:   begin is_cmp = 1'b1; cmp = (a_i == b_i); end
      OP_GT:   begin is_cmp = 1'b1; cmp = (a_i > b_i); end
      OP_SHR:  bw = a_i >> 1;
      OP_SHL:  is_shl = 1'b1;
      default: bw = '0;
    endcase
  end

  always_comb begin
    if (is_cmp)      res_o = {{(RES_W-1){1'b0}}, cmp};
    else if (is_shl) res_o = {{(PAD_W-1){1'b0}}, a_i, 1'b0};  // carry-out kept
    else             res_o = {{PAD_W{1'b0}}, bw};
  end
endmodule

// File: rtl/alu14_outreg.sv
module alu14_outreg #(
  parameter int unsigned RES_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [RES_W-1:0] next_i,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= en_i;
      if (en_i) result_o <= next_i;
    end
  end
endmodule

// File: rtl/alu14_top.sv
module alu14_top
  import alu14_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned RES_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [FUNC_W-1:0] func_i,
  output logic [RES_W-1:0]  result_o,
  output logic              valid_o
);
  alu_op_e          op;
  logic [RES_W-1:0] arith_res, logic_res, next_res;
  logic             is_arith;

  assign op       = alu_op_e'(func_i);
  assign is_arith = (func_i[FUNC_W-1:2] == '0);  // codes 0..3

  alu14_arith #(.DATA_W(DATA_W)) u_arith (
    .a_i(op_a_i), .b_i(op_b_i), .op_i(op), .res_o(arith_res)
  );

  alu14_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i(op_a_i), .b_i(op_b_i), .op_i(op), .res_o(logic_res)
  );

  assign next_res = is_arith ? arith_res : logic_res;

  alu14_outreg #(.RES_W(RES_W)) u_outreg (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .next_i(next_res), .result_o(result_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/alu14_chk.sv
module alu14_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned FUNC_W = 4,
  localparam int unsigned RES_W = 2 * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [DATA_W-1:0] op_a_i,
  input logic [DATA_W-1:0] op_b_i,
  input logic [FUNC_W-1:0] func_i,
  input logic [RES_W-1:0]  result_o,
  input logic              valid_o
);
  logic live_q;  // one clean cycle since reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (result_o == '0 && !valid_o)
        else $error("reset state not clear");
    end
  end

  assert_valid_follows_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> (valid_o == $past(en_i)));

  assert_hold_when_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !$past(en_i)) |-> $stable(result_o));

  assert_div_zero_ones_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(en_i) && $past(func_i) == 4'd3 && $past(op_b_i) == '0)
      |-> (result_o == {RES_W{1'b1}}));

  assert_cmp_single_bit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(en_i) && ($past(func_i) == 4'd10 || $past(func_i) == 4'd11))
      |-> (result_o[RES_W-1:1] == '0));

  assert_reserved_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(en_i) && $past(func_i) >= 4'd14) |-> (result_o == '0 && valid_o));

  assert_logic_upper_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(en_i) && $past(func_i) >= 4'd4 && $past(func_i) <= 4'd9)
      |-> (result_o[RES_W-1:DATA_W] == '0));
endmodule

bind alu14_top alu14_chk #(.DATA_W(DATA_W), .FUNC_W(alu14_pkg::FUNC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
  .func_i(func_i), .result_o(result_o), .valid_o(valid_o)
);

// File: tb/alu14_top_tb.sv
module alu14_top_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [7:0]  op_a_i = '0;
  logic [7:0]  op_b_i = '0;
  logic [3:0]  func_i = '0;
  logic [15:0] result_o;
  logic        valid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  alu14_top u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .func_i(func_i), .result_o(result_o), .valid_o(valid_o)
  );

  function automatic logic [15:0] model(input logic [7:0] a, input logic [7:0] b,
                                        input logic [3:0] f);
    logic [15:0] ax, bx;
    ax = {8'h00, a};
    bx = {8'h00, b};
    case (f)
      4'd0:  return ax + bx;
      4'd1:  return ax - bx;
      4'd2:  return ax * bx;
      4'd3:  return (b == 0) ? 16'hFFFF : ax / bx;
      4'd4:  return {8'h00, a & b};
      4'd5:  return {8'h00, a | b};
      4'd6:  return {8'h00, ~(a & b)};
      4'd7:  return {8'h00, ~(a | b)};
      4'd8:  return {8'h00, a ^ b};
      4'd9:  return {8'h00, ~(a ^ b)};
      4'd10: return {15'd0, a == b};
      4'd11: return {15'd0, a > b};
      4'd12: return {8'h00, a >> 1};
      4'd13: return {7'd0, a, 1'b0};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act_r, input logic act_v,
                       input logic [15:0] exp_r, input logic exp_v);
    n_chk++;
    if (act_r !== exp_r || act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s: result=%h valid=%b expected result=%h valid=%b",
               req, act_r, act_v, exp_r, exp_v);
    end
  endtask

  // drive at negedge, one capture edge, sample at next negedge
  task automatic run_op(input string req, input logic [7:0] a, input logic [7:0] b,
                        input logic [3:0] f);
    @(negedge clk_i);
    op_a_i = a; op_b_i = b; func_i = f; en_i = 1'b1;
    @(negedge clk_i);
    check(req, result_o, valid_o, model(a, b, f), 1'b1);
  endtask

  task automatic t_reset();
    #1;
    check("R1 reset", result_o, valid_o, 16'h0000, 1'b0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release idle", result_o, valid_o, 16'h0000, 1'b0);
  endtask

  task automatic t_arith();
    run_op("R4 add", 8'hFF, 8'h01, 4'd0);
    run_op("R4 add small", 8'h12, 8'h34, 4'd0);
    run_op("R5 sub pos", 8'h50, 8'h20, 4'd1);
    run_op("R5 sub neg", 8'h03, 8'h05, 4'd1);
    run_op("R6 mul max", 8'hFF, 8'hFF, 4'd2);
    run_op("R6 mul", 8'h0C, 8'h0B, 4'd2);
    run_op("R7 div", 8'hC8, 8'h07, 4'd3);
    run_op("R7 div zero", 8'h42, 8'h00, 4'd3);
  endtask

  task automatic t_logic();
    for (int f = 4; f <= 9; f++) begin
      run_op("R8 bitwise", 8'hC3, 8'hA5, 4'(f));
    end
  endtask

  task automatic t_compare();
    run_op("R9 eq true", 8'h5A, 8'h5A, 4'd10);
    run_op("R9 eq false", 8'h5A, 8'h5B, 4'd10);
    run_op("R9 gt true", 8'h80, 8'h7F, 4'd11);
    run_op("R9 gt equal", 8'h33, 8'h33, 4'd11);
  endtask

  task automatic t_shift();
    run_op("R10 shr", 8'h81, 8'h00, 4'd12);
    run_op("R10 shl carry", 8'hC1, 8'h00, 4'd13);
  endtask

  task automatic t_reserved();
    run_op("R11 code14", 8'hFF, 8'hFF, 4'd14);
    run_op("R11 code15", 8'h12, 8'h34, 4'd15);
  endtask

  task automatic t_back_to_back();
    @(negedge clk_i);
    op_a_i = 8'h10; op_b_i = 8'h20; func_i = 4'd0; en_i = 1'b1;
    @(negedge clk_i);
    check("R2 b2b first", result_o, valid_o, 16'h0030, 1'b1);
    op_a_i = 8'h0F; op_b_i = 8'h10; func_i = 4'd2;
    @(negedge clk_i);
    check("R2 b2b second", result_o, valid_o, 16'h00F0, 1'b1);
  endtask

  task automatic t_hold();
    logic [15:0] kept;
    run_op("R2 load", 8'h09, 8'h0A, 4'd2);
    kept = model(8'h09, 8'h0A, 4'd2);
    en_i = 1'b0; op_a_i = 8'hFF; op_b_i = 8'h01; func_i = 4'd0;
    @(negedge clk_i);
    check("R3 hold drop", result_o, valid_o, kept, 1'b0);
    op_a_i = 8'h00; func_i = 4'd6;
    @(negedge clk_i);
    check("R3 hold still", result_o, valid_o, kept, 1'b0);
  endtask

  task automatic t_reset_collide();
    @(negedge clk_i);
    op_a_i = 8'hFF; op_b_i = 8'hFF; func_i = 4'd2; en_i = 1'b1;
    @(posedge clk_i);
    #1 rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 reset beats enable", result_o, valid_o, 16'h0000, 1'b0);
    @(negedge clk_i);
    check("R1 reset holds", result_o, valid_o, 16'h0000, 1'b0);
    en_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    t_reset();
    t_arith();
    t_logic();
    t_compare();
    t_shift();
    t_reserved();
    t_back_to_back();
    t_hold();
    t_reset_collide();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule